// File: doc/BRIEF.md
# Parallel EEPROM Page-Write Sequencer

This block is the control core of a byte-wide parallel EEPROM, reduced to synchronous logic. A host drives active-low chip enable, output enable and write enable, a 17-bit address and an 8-bit data bus. The bus is split into a data input, a data output and an output-drive enable. Bytes written by the host go into a 128-byte page register. Each byte load restarts a load window. When the window runs out with no further load, a self-timed program cycle copies every loaded byte into a behavioural storage array. While that cycle runs, reads return a status byte instead of array data, so software can poll for completion. All intervals are counted in clock cycles.

The address splits into a byte offset (bits 6:0) and a page index (bits 16:7). The storage holds `STORE_PAGES` pages (a power of two), and the page index is folded modulo that count. This keeps the model small while the full address width stays visible at the ports.

The controller has five states:
- `ST_INHIBIT`, entered from reset: writes are locked out.
- `ST_IDLE`: waiting, with an empty page register.
- `ST_STROBE`: a load strobe is in progress.
- `ST_WINDOW`: at least one byte is loaded and the load window is running.
- `ST_PROGRAM`: the self-timed write.

Its transitions:
- reset enters `ST_INHIBIT`.
- `ST_INHIBIT` goes to `ST_IDLE` once the lock-out count expires.
- `ST_IDLE` or `ST_WINDOW` goes to `ST_STROBE` when a load strobe is seen.
- `ST_STROBE` goes to `ST_WINDOW` on strobe release, if the pulse was long enough or a byte is already held.
- `ST_STROBE` returns to `ST_IDLE` after a short pulse with nothing held.
- `ST_WINDOW` goes to `ST_PROGRAM` when the window expires.
- `ST_PROGRAM` goes to `ST_IDLE` when the program count ends.

Top module: `eeprom_page_seq`

## Requirements
- R1: A read access (ce_n=0, oe_n=0, we_n=1) outside the program cycle returns, one clock later on dout, the stored byte at page index addr[16:7] modulo STORE_PAGES and offset addr[6:0]. After reset every stored byte reads 8'hFF.
- R2: dout_en rises one clock after a read access is sampled and is low one clock after any cycle with ce_n=1 or with no read access. dout is 0 when dout_en is low and after reset.
- R3: A load strobe is ce_n=0, oe_n=1 and we_n=0. When the strobe is released after being sampled active for at least MIN_PULSE clocks, the address and data of its last active clock are loaded into the page register. With oe_n=0 nothing is loaded.
- R4: A strobe sampled active for fewer than MIN_PULSE clocks loads nothing. If nothing was already held, no program cycle follows.
- R5: The program cycle begins LOAD_WIN clocks after the release of the last accepted strobe. A new strobe seen within that window stops it, and reads in the window return array data.
- R6: The program cycle lasts PROG_CYC clocks. At its end, each loaded offset of the page is updated and every other byte keeps its value.
- R7: Every byte of one page load is written to the page index of the first byte loaded, whatever page index the later loads carry.
- R8: A read during the program cycle returns a status byte. Bit 7 is the inverse of bit 7 of the last loaded byte, and bits 5:0 are zero.
- R9: Status bit 6 is 1 on the first read access of a program cycle and inverts on each later read access of the same cycle.
- R10: Load strobes during the program cycle are ignored and are never written.
- R11: For INHIBIT_CYC clocks after reset, load strobes are ignored.
- R12: After a program cycle the page register is empty, so the next program cycle writes only the bytes loaded after it.
- R13: One program cycle writes any number of bytes from 1 to 128, including offset 127. A repeated load to the same offset keeps the last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 17 | Byte address: page index in bits 16:7, offset in bits 6:0 |
| din | input | 8 | Data written by the host |
| dout | output | 8 | Registered read data or status byte |
| dout_en | output | 1 | Drive enable for dout, registered |

## Verification
The bench targets the window boundary. A second load arriving two clocks before expiry must hold the program cycle off. A design that let the timer run on would program early and split the page across two cycles. Pulses of exactly MIN_PULSE and one clock less are both driven: an off-by-one filter would either lose the shortest legal byte or accept a glitch and start a spurious program cycle. Status polls check that bit 7 follows the last byte and that bit 6 alternates per read access rather than per clock, and a design toggling every cycle would return the wrong bit on a second read. Loads with a foreign page index, loads during programming and a following program cycle to another page expose a design that re-targets the page, accepts writes while busy, or forgets to clear the page register.

// File: rtl/eps_pkg.sv
package eps_pkg;
    typedef enum logic [2:0] {
        ST_INHIBIT,
        ST_IDLE,
        ST_STROBE,
        ST_WINDOW,
        ST_PROGRAM
    } eps_state_e;
endpackage

// File: rtl/eps_bus_decode.sv
// Classifies the control pins into a load strobe and a read access,
// and marks the first clock of each read access.
module eps_bus_decode (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    output logic load_strobe,
    output logic read_access,
    output logic read_start
);
    logic read_prev;

    assign load_strobe = !ce_n && oe_n && !we_n;
    assign read_access = !ce_n && !oe_n && we_n;
    assign read_start  = read_access && !read_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            read_prev <= 1'b0;
        end else begin
            read_prev <= read_access;
        end
    end
endmodule

// File: rtl/eps_page_buffer.sv
// Page register: one byte and one valid flag per offset, the page
// index of the first load, and the top bit of the most recent byte.
module eps_page_buffer #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8,
    parameter int PAGE_W = 7,
    localparam int PB     = 1 << PAGE_W,
    localparam int PIDX_W = ADDR_W - PAGE_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load_en,
    input  logic [ADDR_W-1:0]          load_addr,
    input  logic [DATA_W-1:0]          load_data,
    input  logic                       clear,
    output logic                       has_data,
    output logic [PIDX_W-1:0]          page_idx,
    output logic [PB-1:0][DATA_W-1:0]  bytes,
    output logic [PB-1:0]              valid,
    output logic                       last_msb
);
    logic [PAGE_W-1:0] offset;

    assign offset = load_addr[PAGE_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid    <= '0;
            has_data <= 1'b0;
            page_idx <= '0;
            last_msb <= 1'b0;
        end else if (clear) begin
            valid    <= '0;
            has_data <= 1'b0;
        end else if (load_en) begin
            if (!has_data) begin
                page_idx <= load_addr[ADDR_W-1:PAGE_W];
            end
            has_data      <= 1'b1;
            valid[offset] <= 1'b1;
            last_msb      <= load_data[DATA_W-1];
        end
    end

    always_ff @(posedge clk) begin
        if (load_en) begin
            bytes[offset] <= load_data;
        end
    end
endmodule

// File: rtl/eps_array.sv
// Behavioural storage: STORE_PAGES pages, erased to all ones on reset.
// A program pulse writes every valid byte of the page register at once.
module eps_array #(
    parameter int ADDR_W      = 17,
    parameter int DATA_W      = 8,
    parameter int PAGE_W      = 7,
    parameter int STORE_PAGES = 8,
    localparam int PB     = 1 << PAGE_W,
    localparam int PIDX_W = ADDR_W - PAGE_W,
    localparam int DEPTH  = STORE_PAGES * PB,
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       prog_en,
    input  logic [PIDX_W-1:0]          prog_page,
    input  logic [PB-1:0][DATA_W-1:0]  prog_bytes,
    input  logic [PB-1:0]              prog_valid,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [DATA_W-1:0]          rd_data
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [IDX_W-1:0]  prog_base;
    logic [IDX_W-1:0]  rd_idx;

    assign prog_base = IDX_W'(int'(prog_page % PIDX_W'(STORE_PAGES)) * PB);
    assign rd_idx    = IDX_W'(int'(rd_addr[ADDR_W-1:PAGE_W] % PIDX_W'(STORE_PAGES)) * PB
                              + int'(rd_addr[PAGE_W-1:0]));
    assign rd_data   = mem[rd_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '1;
            end
        end else if (prog_en) begin
            for (int j = 0; j < PB; j++) begin
                if (prog_valid[j]) begin
                    mem[prog_base + IDX_W'(j)] <= prog_bytes[j];
                end
            end
        end
    end
endmodule

// File: rtl/eeprom_page_seq.sv
module eeprom_page_seq #(
    parameter int ADDR_W      = 17,
    parameter int DATA_W      = 8,
    parameter int PAGE_W      = 7,
    parameter int STORE_PAGES = 8,
    parameter int MIN_PULSE   = 2,
    parameter int LOAD_WIN    = 10000,
    parameter int PROG_CYC    = 500000,
    parameter int INHIBIT_CYC = 1000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);
    import eps_pkg::*;

    localparam int PB     = 1 << PAGE_W;
    localparam int PIDX_W = ADDR_W - PAGE_W;
    localparam int MAX_A  = (LOAD_WIN > PROG_CYC) ? LOAD_WIN : PROG_CYC;
    localparam int MAX_C  = (MAX_A > INHIBIT_CYC) ? MAX_A : INHIBIT_CYC;
    localparam int CNT_W  = $clog2(MAX_C + 1);
    localparam int PW_W   = $clog2(MIN_PULSE + 1);

    eps_state_e state, nxt;

    logic [CNT_W-1:0]          cnt;
    logic [PW_W-1:0]           pw;
    logic                      load_strobe, read_access, read_start;
    logic [ADDR_W-1:0]         lat_addr;
    logic [DATA_W-1:0]         lat_data;
    logic                      has_data, last_msb;
    logic [PIDX_W-1:0]         page_idx;
    logic [PB-1:0][DATA_W-1:0] pg_bytes;
    logic [PB-1:0]             pg_valid;
    logic [DATA_W-1:0]         arr_data;
    logic                      toggle;
    logic                      pulse_ok, commit, inhibit, busy, prog_last;

    eps_bus_decode u_decode (
        .clk         (clk),
        .rst_n       (rst_n),
        .ce_n        (ce_n),
        .oe_n        (oe_n),
        .we_n        (we_n),
        .load_strobe (load_strobe),
        .read_access (read_access),
        .read_start  (read_start)
    );

    assign pulse_ok  = (pw >= PW_W'(MIN_PULSE));
    assign inhibit   = (state == ST_INHIBIT);
    assign busy      = (state == ST_PROGRAM);
    assign prog_last = busy && (cnt == CNT_W'(PROG_CYC - 1));
    assign commit    = (state == ST_STROBE) && !load_strobe && pulse_ok;

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_INHIBIT: if (cnt == CNT_W'(INHIBIT_CYC - 1)) nxt = ST_IDLE;
            ST_IDLE:    if (load_strobe) nxt = ST_STROBE;
            ST_STROBE: begin
                if (!load_strobe) begin
                    nxt = (pulse_ok || has_data) ? ST_WINDOW : ST_IDLE;
                end
            end
            ST_WINDOW: begin
                if (load_strobe) begin
                    nxt = ST_STROBE;
                end else if (cnt == CNT_W'(LOAD_WIN - 1)) begin
                    nxt = ST_PROGRAM;
                end
            end
            ST_PROGRAM: if (cnt == CNT_W'(PROG_CYC - 1)) nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_INHIBIT;
        end else begin
            state <= nxt;
        end
    end

    // interval counter, pulse width, byte latch and toggle bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            pw       <= '0;
            lat_addr <= '0;
            lat_data <= '0;
            toggle   <= 1'b0;
        end else begin
            cnt <= (nxt != state) ? '0 : cnt + 1'b1;
            if (load_strobe && (nxt == ST_STROBE)) begin
                lat_addr <= addr;
                lat_data <= din;
                if (state != ST_STROBE) begin
                    pw <= PW_W'(1);
                end else if (!pulse_ok) begin
                    pw <= pw + 1'b1;
                end
            end
            if ((nxt == ST_PROGRAM) && !busy) begin
                toggle <= 1'b0;
            end else if (busy && read_start) begin
                toggle <= ~toggle;
            end
        end
    end

    eps_page_buffer #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .PAGE_W (PAGE_W)
    ) u_page (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (commit),
        .load_addr (lat_addr),
        .load_data (lat_data),
        .clear     (prog_last),
        .has_data  (has_data),
        .page_idx  (page_idx),
        .bytes     (pg_bytes),
        .valid     (pg_valid),
        .last_msb  (last_msb)
    );

    eps_array #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .PAGE_W      (PAGE_W),
        .STORE_PAGES (STORE_PAGES)
    ) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .prog_en    (prog_last),
        .prog_page  (page_idx),
        .prog_bytes (pg_bytes),
        .prog_valid (pg_valid),
        .rd_addr    (addr),
        .rd_data    (arr_data)
    );

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout    <= '0;
            dout_en <= 1'b0;
        end else begin
            dout_en <= read_access;
            if (!read_access) begin
                dout <= '0;
            end else if (busy) begin
                dout <= {~last_msb, (read_start ? ~toggle : toggle), {(DATA_W-2){1'b0}}};
            end else begin
                dout <= arr_data;
            end
        end
    end
endmodule

// File: rtl/eps_checker.sv
module eps_checker #(
    parameter int DATA_W = 8,
    parameter int PB     = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              oe_n,
    input logic              we_n,
    input logic [DATA_W-1:0] dout,
    input logic              dout_en,
    input logic              busy,
    input logic              prog_last,
    input logic              inhibit,
    input logic              has_data,
    input logic              last_msb,
    input logic [PB-1:0]     pg_valid
);
    assert_standby_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> !dout_en);

    assert_read_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && we_n) |=> dout_en);

    assert_status_msb_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ce_n && !oe_n && we_n) |=> (dout[DATA_W-1] == !$past(last_msb)));

    assert_status_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ce_n && !oe_n && we_n) |=> (dout[DATA_W-3:0] == '0));

    assert_busy_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !prog_last) |=> $stable(pg_valid));

    assert_page_cleared_R12: assert property (@(posedge clk) disable iff (!rst_n)
        prog_last |=> !has_data);

    assert_inhibit_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit |-> !has_data);
endmodule

bind eeprom_page_seq eps_checker #(
    .DATA_W (DATA_W),
    .PB     (1 << PAGE_W)
) i_eps_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .dout      (dout),
    .dout_en   (dout_en),
    .busy      (busy),
    .prog_last (prog_last),
    .inhibit   (inhibit),
    .has_data  (has_data),
    .last_msb  (last_msb),
    .pg_valid  (pg_valid)
);

// File: tb/test_eeprom_page_seq.sv
`timescale 1ns/1ps
module test_eeprom_page_seq;
    localparam int LW = 20;
    localparam int PC = 40;
    localparam int MP = 3;
    localparam int IC = 30;
    localparam int SP = 4;

    localparam int M_INH = 0, M_IDL = 1, M_STB = 2, M_WIN = 3, M_PRG = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [16:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic        dout_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    eeprom_page_seq #(
        .STORE_PAGES (SP),
        .MIN_PULSE   (MP),
        .LOAD_WIN    (LW),
        .PROG_CYC    (PC),
        .INHIBIT_CYC (IC)
    ) i_eeprom_page_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_n    (ce_n),
        .oe_n    (oe_n),
        .we_n    (we_n),
        .addr    (addr),
        .din     (din),
        .dout    (dout),
        .dout_en (dout_en)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int          m_mode, m_cnt, m_pw, m_page, m_lat_a;
    logic [7:0]  m_lat_d;
    bit          m_have, m_last7, m_tog, m_rdp, exp_en, exp_stat;
    logic [7:0]  exp_d;
    logic [7:0]  m_buf[int];
    logic [7:0]  m_mem[int];

    function automatic logic [7:0] mrd(int a);
        int idx = (((a >> 7) % SP) * 128) + (a & 127);
        return m_mem.exists(idx) ? m_mem[idx] : 8'hFF;
    endfunction

    always @(posedge clk) begin
        bit stb, rdc;
        if (!rst_n) begin
            m_mode = M_INH; m_cnt = 0; m_pw = 0; m_have = 0; m_tog = 0; m_rdp = 0;
            m_last7 = 0; m_buf.delete(); m_mem.delete();
            exp_d = 8'h00; exp_en = 0; exp_stat = 0;
        end else begin
            stb = !ce_n && oe_n && !we_n;
            rdc = !ce_n && !oe_n && we_n;
            exp_en = rdc;
            exp_stat = 0;
            if (!rdc) begin
                exp_d = 8'h00;
            end else if (m_mode == M_PRG) begin
                if (!m_rdp) m_tog = !m_tog;
                exp_d = {!m_last7, m_tog, 6'b0};
                exp_stat = 1;
            end else begin
                exp_d = mrd(int'(addr));
            end
            m_rdp = rdc;
            case (m_mode)
                M_INH: if (m_cnt == IC - 1) begin m_mode = M_IDL; m_cnt = 0; end else m_cnt++;
                M_IDL: if (stb) begin m_mode = M_STB; m_pw = 1; m_lat_a = int'(addr); m_lat_d = din; end
                M_STB: begin
                    if (stb) begin
                        m_pw++; m_lat_a = int'(addr); m_lat_d = din;
                    end else begin
                        if (m_pw >= MP) begin
                            if (!m_have) m_page = m_lat_a >> 7;
                            m_have = 1;
                            m_buf[m_lat_a & 127] = m_lat_d;
                            m_last7 = m_lat_d[7];
                        end
                        if (m_pw >= MP || m_have) begin m_mode = M_WIN; m_cnt = 0; end
                        else m_mode = M_IDL;
                    end
                end
                M_WIN: begin
                    if (stb) begin
                        m_mode = M_STB; m_pw = 1; m_lat_a = int'(addr); m_lat_d = din;
                    end else if (m_cnt == LW - 1) begin
                        m_mode = M_PRG; m_cnt = 0; m_tog = 0;
                    end else m_cnt++;
                end
                default: begin
                    if (m_cnt == PC - 1) begin
                        foreach (m_buf[o]) m_mem[((m_page % SP) * 128) + o] = m_buf[o];
                        m_buf.delete();
                        m_have = 0; m_mode = M_IDL; m_cnt = 0;
                    end else m_cnt++;
                end
            endcase
        end
    end

    // every-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R2 dout_en per clock", dout_en, exp_en);
            check(exp_stat ? "R8/R9 status per clock" : "R1 dout per clock", dout, exp_d);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load(input logic [16:0] a, input logic [7:0] d, input int len);
        ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b0; addr = a; din = d;
        tick(len);
        we_n = 1'b1; ce_n = 1'b1;
    endtask

    task automatic rd(input logic [16:0] a, output logic [7:0] q, output logic en);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
        tick(1);
        q = dout; en = dout_en;
        ce_n = 1'b1; oe_n = 1'b1;
        tick(1);
    endtask

    task automatic expect_byte(input string tag, input logic [16:0] a, input logic [7:0] e);
        logic [7:0] q;
        logic en;
        rd(a, q, en);
        check(tag, en, 1'b1);
        check(tag, q, e);
    endtask

    initial begin
        #(4 * 100000);
        checks++; errors++;
        $display("FAIL watchdog: got hung expected completion");
        finish_run();
    end

    initial begin
        tick(3);
        check("R2 reset dout_en", dout_en, 1'b0);
        check("R2 reset dout", dout, 8'h00);
        rst_n = 1'b1;
        tick(2);

        // R11: load during lock-out is dropped; R1 erased contents
        load(17'h00001, 8'h12, 4);
        expect_byte("R1 erased read", 17'h00001, 8'hFF);
        tick(IC + LW + PC + 10);
        expect_byte("R11 inhibited load absent", 17'h00001, 8'hFF);

        // R3/R8/R9/R6: single byte at minimum pulse width
        load(17'h00085, 8'h5A, MP);
        tick(LW + 2);
        expect_byte("R8/R9 first status poll", 17'h00085, 8'hC0);
        expect_byte("R9 second status poll", 17'h00085, 8'h80);
        tick(PC);
        expect_byte("R3 R6 byte programmed", 17'h00085, 8'h5A);
        expect_byte("R6 neighbour untouched", 17'h00086, 8'hFF);

        // R4: one clock short of the minimum
        load(17'h000C0, 8'h77, MP - 1);
        tick(LW + 2);
        expect_byte("R4 no program after glitch", 17'h000C0, 8'hFF);
        tick(PC);
        expect_byte("R4 glitch byte absent", 17'h000C0, 8'hFF);

        // R3: oe_n low blocks a load
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0; addr = 17'h001C0; din = 8'h3C;
        tick(4);
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
        tick(LW + PC + 5);
        expect_byte("R3 oe_n low blocks load", 17'h001C0, 8'hFF);

        // R5/R7/R13: multi-byte page with window holds
        load(17'h00103, 8'h31, MP);
        tick(LW - 2);
        load(17'h0017F, 8'h7F, MP + 2);
        tick(5);
        load(17'h00010, 8'h44, MP);
        tick(LW - 1);
        load(17'h00103, 8'h99, MP);
        tick(LW);
        expect_byte("R5 window still open", 17'h00103, 8'hFF);
        expect_byte("R8/R9 status after window", 17'h00103, 8'h40);
        tick(PC);
        expect_byte("R13 last value kept", 17'h00103, 8'h99);
        expect_byte("R13 offset 127 written", 17'h0017F, 8'h7F);
        expect_byte("R7 foreign page retargeted", 17'h00110, 8'h44);
        expect_byte("R7 foreign page untouched", 17'h00010, 8'hFF);
        expect_byte("R1 page alias", 17'h00303, 8'h99);

        // R10/R12: loads while busy, then a fresh page
        load(17'h00189, 8'h22, MP);
        tick(LW + 3);
        load(17'h0018A, 8'h33, MP + 1);
        tick(PC);
        expect_byte("R12 new byte written", 17'h00189, 8'h22);
        expect_byte("R10 busy load ignored", 17'h0018A, 8'hFF);
        expect_byte("R12 old page bytes not reapplied", 17'h00185, 8'hFF);
        expect_byte("R12 old page bytes not reapplied", 17'h00183, 8'hFF);

        // R2: standby keeps the bus undriven
        ce_n = 1'b1; oe_n = 1'b0; we_n = 1'b1;
        tick(1);
        check("R2 standby dout_en", dout_en, 1'b0);
        oe_n = 1'b1;
        tick(5);
        finish_run();
    end
endmodule